// File: doc/BRIEF.md
# Segmented SIMD Adder/Subtractor

This block adds or subtracts two 48-bit words in a single registered stage. One operand, called X here, is formed by placing a 30-bit high input above an 18-bit low input. The other operand, Z, is a plain 48-bit input. A lane-mode input splits the datapath into independent lanes at run time: one 48-bit lane, two 24-bit lanes, or four 12-bit lanes. Carries never cross a lane boundary. Each lane reports its own carry on a 4-bit vector.

The datapath is built from four 12-bit slices joined by a carry chain. At every slice boundary the chain either passes the carry on or cuts it, depending on the mode. A selectable carry source feeds only the lowest lane. In subtract mode every lane computes Z - X by inverting X and forcing its own carry-in to one. The result and the carry vector update on a rising edge when the clock enable is high. A synchronous reset clears both.

Top module: `simd_lane_adder`

## Requirements
- R1: Mode code 0 (single lane) with sub=0 gives result = (Z + X + c0) mod 2^48, where X = {opa_hi, opb_lo}, Z = opc and c0 is the selected carry-in. cout[3] holds the carry out of bit 47.
- R2: With sub=1, each lane's result is (Z - X) mod 2^W for that lane's width W. The lane's carry bit is 1 when no borrow occurs (Z field >= X field) and 0 otherwise.
- R3: Mode code 1 (two lanes) splits the word at bit 24, and the two halves are computed independently. cout[1] is the carry of bits 23:0, cout[3] is the carry of bits 47:24, and cout[0] and cout[2] are 0.
- R4: Mode code 2 (four lanes) splits the word into 12-bit fields at bits 12, 24 and 36, and the fields are computed independently. cout[i] is the carry of field i, where field 0 is bits 11:0.
- R5: In single-lane mode cout[2:0] is 0. Mode code 3 behaves exactly like mode code 0.
- R6: During addition, cin_src selects the carry-in of the lowest lane: 0 gives zero, 1 gives cin_ext, 2 gives one, and 3 gives the registered cout[3]. During addition every upper lane gets a carry-in of 0.
- R7: During subtraction, cin_src and cin_ext have no effect on the result or the carry vector.
- R8: While ce is low and rst is low, result and cout keep their values.
- R9: A high rst on a rising edge clears result and cout to zero, whatever the value of ce.
- R10: Inputs present at a rising edge with ce high appear on result and cout right after that edge, and not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ce | input | 1 | Clock enable for the output registers |
| lane_mode | input | 2 | 0/3: one 48-bit lane, 1: two 24-bit lanes, 2: four 12-bit lanes |
| sub | input | 1 | 1 selects Z - X, 0 selects Z + X |
| cin_src | input | 2 | Carry-in source for the lowest lane: 0 zero, 1 cin_ext, 2 one, 3 registered cout[3] |
| cin_ext | input | 1 | External carry-in bit |
| opa_hi | input | 30 | Upper 30 bits of operand X |
| opb_lo | input | 18 | Lower 18 bits of operand X |
| opc | input | 48 | Operand Z |
| result | output | 48 | Registered sum or difference |
| cout | output | 4 | Registered per-lane carry vector |

## Verification
The only state in this block is the output register, so a wrong boundary cut or a wrong lane carry-in shows on result and cout one edge after the bad operands are applied. The vectors therefore place all-ones fields next to ones in small values, so that a carry leaking across a boundary changes the neighbouring field. Fault in the stored top carry stays hidden until an operation selects it as the carry source, so the tests use that source right after an overflow and right after reset. A failed hold under a low enable shows at the next edge as changed outputs.

// File: rtl/simd_pkg.sv
package simd_pkg;
  typedef enum logic [1:0] {
    LM_ONE48  = 2'd0,
    LM_TWO24  = 2'd1,
    LM_FOUR12 = 2'd2,
    LM_ALT48  = 2'd3
  } lane_mode_e;

  typedef enum logic [1:0] {
    CS_ZERO = 2'd0,
    CS_EXT  = 2'd1,
    CS_ONE  = 2'd2,
    CS_FBK  = 2'd3
  } cin_src_e;
endpackage

// File: rtl/add_slice.sv
module add_slice #(
  parameter int W = 12
) (
  input  logic [W-1:0] z_in,
  input  logic [W-1:0] x_in,
  input  logic         ci,
  output logic [W-1:0] sum,
  output logic         co
);
  logic [W:0] wide;

  always_comb begin
    wide = {1'b0, z_in} + {1'b0, x_in} + {{W{1'b0}}, ci};
  end

  assign sum = wide[W-1:0];
  assign co  = wide[W];
endmodule

// File: rtl/cin_select.sv
module cin_select
  import simd_pkg::*;
(
  input  logic [1:0] src,
  input  logic       ext_bit,
  input  logic       fbk_bit,
  output logic       cin
);
  always_comb begin
    unique case (cin_src_e'(src))
      CS_ZERO: cin = 1'b0;
      CS_EXT:  cin = ext_bit;
      CS_ONE:  cin = 1'b1;
      default: cin = fbk_bit;
    endcase
  end
endmodule

// File: rtl/lane_ctrl.sv
module lane_ctrl
  import simd_pkg::*;
#(
  parameter int NSLICE = 4
) (
  input  logic [1:0]        mode,
  input  logic              sub,
  input  logic              cin0,
  output logic [NSLICE-1:0] cut,
  output logic [NSLICE-1:0] lane_ci,
  output logic [NSLICE-1:0] lane_top
);
  localparam int HALF = NSLICE / 2;

  logic is_four;
  logic is_two;

  assign is_four = (lane_mode_e'(mode) == LM_FOUR12);
  assign is_two  = (lane_mode_e'(mode) == LM_TWO24);

  for (genvar i = 0; i < NSLICE; i++) begin : g_slice
    localparam bit AT_HALF = ((i % HALF) == 0);

    if (i == 0) begin : g_low
      assign cut[i]     = 1'b1;
      assign lane_ci[i] = sub | cin0;
    end else begin : g_up
      assign cut[i]     = is_four | (is_two & AT_HALF);
      assign lane_ci[i] = sub;
    end

    if (i == NSLICE - 1) begin : g_msb
      assign lane_top[i] = 1'b1;
    end else begin : g_mid
      assign lane_top[i] = cut[i+1];
    end
  end
endmodule

// File: rtl/simd_lane_adder.sv
module simd_lane_adder
  import simd_pkg::*;
#(
  parameter int SLICE_W = 12,
  parameter int NSLICE  = 4,
  parameter int AW      = 30
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        ce,
  input  logic [1:0]                  lane_mode,
  input  logic                        sub,
  input  logic [1:0]                  cin_src,
  input  logic                        cin_ext,
  input  logic [AW-1:0]               opa_hi,
  input  logic [SLICE_W*NSLICE-AW-1:0] opb_lo,
  input  logic [SLICE_W*NSLICE-1:0]   opc,
  output logic [SLICE_W*NSLICE-1:0]   result,
  output logic [NSLICE-1:0]           cout
);
  localparam int DW = SLICE_W * NSLICE;

  logic [DW-1:0]     x_word;
  logic [DW-1:0]     x_eff;
  logic [DW-1:0]     sum_d;
  logic              cin0;
  logic [NSLICE-1:0] cut;
  logic [NSLICE-1:0] lane_ci;
  logic [NSLICE-1:0] lane_top;
  logic [NSLICE-1:0] slice_ci;
  logic [NSLICE-1:0] slice_co;

  assign x_word = {opa_hi, opb_lo};
  assign x_eff  = sub ? ~x_word : x_word;

  cin_select u_cin (
    .src     (cin_src),
    .ext_bit (cin_ext),
    .fbk_bit (cout[NSLICE-1]),
    .cin     (cin0)
  );

  lane_ctrl #(.NSLICE(NSLICE)) u_ctrl (
    .mode     (lane_mode),
    .sub      (sub),
    .cin0     (cin0),
    .cut      (cut),
    .lane_ci  (lane_ci),
    .lane_top (lane_top)
  );

  for (genvar i = 0; i < NSLICE; i++) begin : g_chain
    if (i == 0) begin : g_first
      assign slice_ci[i] = lane_ci[i];
    end else begin : g_next
      assign slice_ci[i] = cut[i] ? lane_ci[i] : slice_co[i-1];
    end

    add_slice #(.W(SLICE_W)) u_slice (
      .z_in (opc[i*SLICE_W +: SLICE_W]),
      .x_in (x_eff[i*SLICE_W +: SLICE_W]),
      .ci   (slice_ci[i]),
      .sum  (sum_d[i*SLICE_W +: SLICE_W]),
      .co   (slice_co[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result <= '0;
      cout   <= '0;
    end else if (ce) begin
      result <= sum_d;
      cout   <= slice_co & lane_top;
    end
  end
endmodule

// File: rtl/simd_lane_adder_chk.sv
module simd_lane_adder_chk #(
  parameter int DW = 48,
  parameter int AW = 30
) (
  input logic          clk,
  input logic          rst,
  input logic          ce,
  input logic [1:0]    lane_mode,
  input logic          sub,
  input logic [1:0]    cin_src,
  input logic [AW-1:0] opa_hi,
  input logic [DW-AW-1:0] opb_lo,
  input logic [DW-1:0] opc,
  input logic [DW-1:0] result,
  input logic [3:0]    cout
);
  logic [DW-1:0] xcat;
  assign xcat = {opa_hi, opb_lo};

  p_rst_clear_r9: assert property (@(posedge clk)
    rst |=> (result == '0) && (cout == '0));

  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !ce |=> $stable(result) && $stable(cout));

  p_two_lane_cout_r3: assert property (@(posedge clk) disable iff (rst)
    (ce && lane_mode == 2'd1) |=> (cout[0] == 1'b0) && (cout[2] == 1'b0));

  p_one_lane_cout_r5: assert property (@(posedge clk) disable iff (rst)
    (ce && (lane_mode == 2'd0 || lane_mode == 2'd3)) |=> (cout[2:0] == 3'b000));

  p_lane_cut_r4: assert property (@(posedge clk) disable iff (rst)
    (ce && lane_mode == 2'd2 && !sub && cin_src == 2'd0) |=>
      (result[23:12] == 12'($past(opc[23:12]) + $past(xcat[23:12]))));

  p_sub_low_lane_r7: assert property (@(posedge clk) disable iff (rst)
    (ce && lane_mode == 2'd2 && sub) |=>
      (result[11:0] == 12'($past(opc[11:0]) - $past(xcat[11:0]))));
endmodule

bind simd_lane_adder simd_lane_adder_chk #(.DW(SLICE_W*NSLICE), .AW(AW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ce        (ce),
  .lane_mode (lane_mode),
  .sub       (sub),
  .cin_src   (cin_src),
  .opa_hi    (opa_hi),
  .opb_lo    (opb_lo),
  .opc       (opc),
  .result    (result),
  .cout      (cout)
);

// File: tb/sim_simd_lane_adder.sv
module sim_simd_lane_adder;
  localparam int PERIOD = 10;
  localparam int NVEC   = 12;

  // entry: {mode[2], sub[1], src[2], cin[1], a[30], b[18], c[48]} = 102 bits
  localparam logic [101:0] VEC [NVEC] = '{
    {2'd0, 1'b0, 2'd1, 1'b1, 30'h3FFFFFFF, 18'h3FFFF, 48'h000000000001}, // R1 wrap
    {2'd0, 1'b0, 2'd0, 1'b0, 30'h00001234, 18'h05678, 48'h000011112222}, // R1
    {2'd1, 1'b0, 2'd0, 1'b0, 30'h0000003F, 18'h3FFFF, 48'h000100000001}, // R3 cut at 24
    {2'd2, 1'b0, 2'd0, 1'b0, 30'h3FFFFFFF, 18'h3FFFF, 48'h001001001001}, // R4 all carry
    {2'd2, 1'b0, 2'd1, 1'b1, 30'h00000000, 18'h00000, 48'hFFFFFFFFFFFF}, // R6 low only
    {2'd2, 1'b1, 2'd0, 1'b0, 30'h00180100, 18'h05000, 48'h005005005005}, // R2 four
    {2'd1, 1'b1, 2'd0, 1'b0, 30'h00000400, 18'h00002, 48'h000100000001}, // R2 two
    {2'd0, 1'b1, 2'd0, 1'b0, 30'h00000000, 18'h00001, 48'h000000000000}, // R2 borrow
    {2'd3, 1'b0, 2'd0, 1'b0, 30'h00000000, 18'h00001, 48'h000000FFFFFF}, // R5 alias
    {2'd0, 1'b0, 2'd2, 1'b0, 30'h00000000, 18'h00000, 48'hFFFFFFFFFFFF}, // R6 one
    {2'd0, 1'b0, 2'd3, 1'b0, 30'h00000000, 18'h00000, 48'h000000000005}, // R6 feedback
    {2'd1, 1'b0, 2'd1, 1'b1, 30'h00000000, 18'h00000, 48'h000000FFFFFF}  // R6 ext two
  };

  logic        clk = 1'b0;
  logic        rst;
  logic        ce;
  logic [1:0]  lane_mode;
  logic        sub;
  logic [1:0]  cin_src;
  logic        cin_ext;
  logic [29:0] opa_hi;
  logic [17:0] opb_lo;
  logic [47:0] opc;
  logic [47:0] result;
  logic [3:0]  cout;

  int checks = 0;
  int fails  = 0;
  logic exp_c3 = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  simd_lane_adder u0 (
    .clk(clk), .rst(rst), .ce(ce), .lane_mode(lane_mode), .sub(sub),
    .cin_src(cin_src), .cin_ext(cin_ext), .opa_hi(opa_hi), .opb_lo(opb_lo),
    .opc(opc), .result(result), .cout(cout)
  );

  function automatic logic [51:0] model(input logic [1:0] m, input logic s,
                                        input logic [1:0] src, input logic ci,
                                        input logic fb, input logic [47:0] x,
                                        input logic [47:0] c);
    int nl;
    int w;
    logic [47:0] r;
    logic [3:0]  co;
    logic [48:0] mask;
    logic [48:0] cs;
    logic [48:0] xs;
    logic [48:0] sm;
    logic        c0;
    nl = (m == 2'd1) ? 2 : (m == 2'd2) ? 4 : 1;
    w  = 48 / nl;
    r  = '0;
    co = '0;
    case (src)
      2'd0: c0 = 1'b0;
      2'd1: c0 = ci;
      2'd2: c0 = 1'b1;
      default: c0 = fb;
    endcase
    if (s) c0 = 1'b1;
    mask = (49'd1 << w) - 49'd1;
    for (int k = 0; k < nl; k++) begin
      cs = ({1'b0, c} >> (k * w)) & mask;
      xs = ({1'b0, (s ? ~x : x)} >> (k * w)) & mask;
      sm = cs + xs + ((k == 0) ? {48'd0, c0} : {48'd0, s});
      r  = r | 48'((sm & mask) << (k * w));
      co[(k + 1) * (4 / nl) - 1] = sm[w];
    end
    return {co, r};
  endfunction

  task automatic check(input string tag, input logic [47:0] gr, input logic [47:0] er,
                       input logic [3:0] gc, input logic [3:0] ec);
    checks++;
    if (gr !== er || gc !== ec) begin
      fails++;
      $display("FAIL %s: result=%h cout=%b expected result=%h cout=%b", tag, gr, gc, er, ec);
    end
  endtask

  task automatic drive(input logic [1:0] m, input logic s, input logic [1:0] src,
                       input logic ci, input logic [29:0] a, input logic [17:0] b,
                       input logic [47:0] c);
    lane_mode = m; sub = s; cin_src = src; cin_ext = ci;
    opa_hi = a; opb_lo = b; opc = c;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run_one(input string tag, input logic [1:0] m, input logic s,
                         input logic [1:0] src, input logic ci, input logic [29:0] a,
                         input logic [17:0] b, input logic [47:0] c);
    logic [51:0] e;
    e = model(m, s, src, ci, exp_c3, {a, b}, c);
    drive(m, s, src, ci, a, b, c);
    ce = 1'b1;
    step();
    exp_c3 = e[51];
    check(tag, result, e[47:0], cout, e[51:48]);
  endtask

  initial begin
    #(PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [47:0] held_r;
    logic [3:0]  held_c;
    logic [51:0] e;
    rst = 1'b1; ce = 1'b0;
    drive(2'd0, 1'b0, 2'd0, 1'b0, '0, '0, '0);
    @(negedge clk);
    step();
    check("R9 reset state", result, 48'd0, cout, 4'd0);
    rst = 1'b0;

    for (int i = 0; i < NVEC; i++) begin
      run_one("R1/R2/R3/R4/R5/R6 table", VEC[i][101:100], VEC[i][99], VEC[i][98:97],
              VEC[i][96], VEC[i][95:66], VEC[i][65:48], VEC[i][47:0]);
    end

    // R7: subtraction ignores carry source and external bit
    run_one("R7 sub src ext", 2'd2, 1'b1, 2'd1, 1'b1, 30'h00040080, 18'h00003,
            48'h123456789ABC);
    run_one("R7 sub src one", 2'd0, 1'b1, 2'd2, 1'b0, 30'h00000000, 18'h00010,
            48'h000000000020);

    // R8: enable low holds outputs
    held_r = result; held_c = cout;
    drive(2'd2, 1'b0, 2'd2, 1'b1, 30'h3FFFFFFF, 18'h3FFFF, 48'hFFFFFFFFFFFF);
    ce = 1'b0;
    step();
    step();
    check("R8 hold with ce low", result, held_r, cout, held_c);

    // R10: no change before the edge, new value right after
    e = model(2'd0, 1'b0, 2'd0, 1'b0, exp_c3, 48'h000000000007, 48'h000000000008);
    held_r = result; held_c = cout;
    drive(2'd0, 1'b0, 2'd0, 1'b0, 30'h0, 18'h00007, 48'h000000000008);
    ce = 1'b1;
    #(PERIOD/4);
    check("R10 before edge", result, held_r, cout, held_c);
    @(posedge clk);
    #1;
    check("R10 after edge", result, e[47:0], cout, e[51:48]);
    @(negedge clk);
    exp_c3 = e[51];

    // set top carry, then R9 reset with ce high clears result and stored carry
    run_one("R1 top carry set", 2'd0, 1'b0, 2'd2, 1'b0, 30'h3FFFFFFF, 18'h3FFFF,
            48'h000000000000);
    rst = 1'b1; ce = 1'b1;
    step();
    rst = 1'b0;
    exp_c3 = 1'b0;
    check("R9 reset with ce high", result, 48'd0, cout, 4'd0);
    run_one("R6 feedback after reset", 2'd0, 1'b0, 2'd3, 1'b0, 30'h0, 18'h0,
            48'h000000000005);

    // R5 alias mode carry ripples across all boundaries
    run_one("R5 mode 3 full ripple", 2'd3, 1'b0, 2'd0, 1'b0, 30'h0, 18'h00001,
            48'h7FFFFFFFFFFF);
    // R4 alternating fields
    run_one("R4 four lane mixed", 2'd2, 1'b0, 2'd0, 1'b0, 30'h00000FFF, 18'h00001,
            48'h0FFF00010FFF);
    // R3 upper lane overflow only
    run_one("R3 upper overflow", 2'd1, 1'b0, 2'd0, 1'b0, 30'h3FFFFFC0, 18'h00000,
            48'h000001000123);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule